// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked host and an external asynchronous static RAM of 131,072 bytes. The RAM has two chip selects of opposite polarity (one active low, one active high), an active-low output enable, an active-low write enable and one shared 8-bit data bus. The host places single-byte requests through a valid/ready handshake. The controller expands each request into a strobe sequence, and it holds every phase of that sequence for a whole number of clock cycles that is set by a parameter.

All memory-side outputs come straight from flops. A write drives the data bus only while write enable is low and output enable is high, so two drivers never share the bus. When a write follows a read closely, the controller adds deselected cycles first. These cover the time the memory takes to release the bus after output enable rises. The tristate pad lies outside the block: the controller provides separate data-out, drive-enable and data-in signals.

The phase lengths are counted in clock cycles and each must be at least 1: `T_AS` (address and select before the write strobe), `T_WP` (write strobe), `T_WR` (recovery), `T_RD` (read access with output enable low), `T_RDH` (read hold) and `T_TA` (bus turnaround, which may be 0).

Top module: `asram_ctrl`

## Requirements
- R1: After reset, and in every cycle where `req_ready` is 1, the strobe vector {cs1_n, cs2, oe_n, we_n, dq_oe} equals 5'b10110: deselected, no output enable, no write, bus released. `rsp_valid` is 0 after reset.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the sequence ends. During that time `mem_addr` and `mem_dq_out` keep the accepted values, whatever the host then drives.
- R3: An accepted write starts with `T_AS` cycles at strobe 5'b01110. It continues with `T_WP` cycles at 5'b01101 and `T_WR` cycles at 5'b01110, then returns to idle with `req_ready` at 1.
- R4: `mem_dq_oe` is 1 only while we_n is 0 and oe_n is 1. During those cycles `mem_dq_out` carries the accepted write byte.
- R5: An accepted read gives `T_RD` cycles at strobe 5'b01010 (output enable low). It then gives `T_RDH` cycles at 5'b01110 and returns to idle.
- R6: The byte on `mem_dq_in` in the last output-enable cycle of a read appears on `rsp_rdata`. `rsp_valid` is 1 for exactly one cycle, the first hold cycle.
- R7: If a write is accepted too soon after a read ends, the controller stays deselected (5'b10110) until at least `T_TA` deselected cycles lie between the read's last cycle and the write's first select cycle. A write that follows another write, or follows a read after `T_TA` or more idle cycles, begins its setup phase in the cycle right after acceptance.
- R8: Addresses at every bit position, all-zero and all-one, are driven unchanged on `mem_addr`. The data written to each address reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, can accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write byte |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_rdata | output | DATA_W | Read byte |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs1_n | output | 1 | Chip select, active low |
| mem_cs2 | output | 1 | Chip select, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | DATA_W | Byte toward the pad |
| mem_dq_oe | output | 1 | Pad driver enable |
| mem_dq_in | input | DATA_W | Byte from the pad |

## Verification
The hardest case to reach is a write accepted while the turnaround window after a read is still open. The host has to present the write in the same cycle the read's hold phase ends. The bench therefore chains a read task directly into a write task without any gap, and it counts the deselected cycles before the write's first select cycle. It repeats the chain with an idle gap longer than the window, which checks that no extra delay appears. The memory model returns junk until output enable has been low for a few cycles, so a capture taken too early shows up as a wrong read byte.

// File: rtl/asram_ctrl_pkg.sv
package asram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_WSET,
        ST_WPUL,
        ST_WREC,
        ST_RACC,
        ST_RHLD
    } ctl_st_e;

    typedef struct packed {
        logic cs1_n;
        logic cs2;
        logic oe_n;
        logic we_n;
        logic drv;
    } strobe_t;

    function automatic strobe_t strobe_for(ctl_st_e s);
        strobe_t sb;
        sb = '{cs1_n: 1'b1, cs2: 1'b0, oe_n: 1'b1, we_n: 1'b1, drv: 1'b0};
        case (s)
            ST_WSET, ST_WREC, ST_RHLD: begin
                sb.cs1_n = 1'b0;
                sb.cs2   = 1'b1;
            end
            ST_WPUL: begin
                sb.cs1_n = 1'b0;
                sb.cs2   = 1'b1;
                sb.we_n  = 1'b0;
                sb.drv   = 1'b1;
            end
            ST_RACC: begin
                sb.cs1_n = 1'b0;
                sb.cs2   = 1'b1;
                sb.oe_n  = 1'b0;
            end
            default: ;
        endcase
        return sb;
    endfunction

endpackage

// File: rtl/phase_timer.sv
module phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);

    AST_TIMER_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> done); // R3

endmodule

// File: rtl/turn_guard.sv
module turn_guard #(
    parameter int TA = 4,
    parameter int W  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic clear
);
    logic [W-1:0] ta_d, ta_q;

    always_comb begin
        ta_d = ta_q;
        if (arm)
            ta_d = W'(TA);
        else if (ta_q != '0)
            ta_d = ta_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ta_q <= '0;
        else        ta_q <= ta_d;
    end

    assign clear = (ta_q == '0);

    AST_GUARD_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm && !clear) |=> (ta_q == $past(ta_q) - 1'b1)); // R7

endmodule

// File: rtl/read_capture.sv
module read_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grab,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] dat;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d     = cap_q;
        cap_d.vld = grab;
        if (grab) cap_d.dat = dq_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign rvalid = cap_q.vld;
    assign rdata  = cap_q.dat;

    AST_RVALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid); // R6

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8,
    parameter int T_AS   = 1,
    parameter int T_WP   = 7,
    parameter int T_WR   = 1,
    parameter int T_RD   = 9,
    parameter int T_RDH  = 1,
    parameter int T_TA   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs1_n,
    output logic              mem_cs2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int MAX_W = (T_AS > T_WP) ? T_AS : T_WP;
    localparam int MAX_X = (MAX_W > T_WR) ? MAX_W : T_WR;
    localparam int MAX_R = (T_RD > T_RDH) ? T_RD : T_RDH;
    localparam int MAX_T = (MAX_X > MAX_R) ? MAX_X : MAX_R;
    localparam int CNT_W = $clog2(MAX_T + 1);
    localparam int TA_W  = $clog2(T_TA + 2);

    typedef struct packed {
        ctl_st_e           st;
        strobe_t           sb;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdat;
        logic              rdy;
    } ctl_regs_t;

    ctl_regs_t        d, q;
    logic             t_done;
    logic             t_load;
    logic [CNT_W-1:0] t_len;
    logic             ta_clear;
    logic             ta_arm;
    logic             grab;

    function automatic logic [CNT_W-1:0] len_of(ctl_st_e s);
        case (s)
            ST_WSET: return CNT_W'(T_AS - 1);
            ST_WPUL: return CNT_W'(T_WP - 1);
            ST_WREC: return CNT_W'(T_WR - 1);
            ST_RACC: return CNT_W'(T_RD - 1);
            ST_RHLD: return CNT_W'(T_RDH - 1);
            default: return '0;
        endcase
    endfunction

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (req_valid && q.rdy) begin
                    d.addr = req_addr;
                    d.wdat = req_wdata;
                    if (req_write) d.st = ta_clear ? ST_WSET : ST_TURN;
                    else           d.st = ST_RACC;
                end
            end
            ST_TURN: if (ta_clear) d.st = ST_WSET;
            ST_WSET: if (t_done)   d.st = ST_WPUL;
            ST_WPUL: if (t_done)   d.st = ST_WREC;
            ST_WREC: if (t_done)   d.st = ST_IDLE;
            ST_RACC: if (t_done)   d.st = ST_RHLD;
            ST_RHLD: if (t_done)   d.st = ST_IDLE;
            default:               d.st = ST_IDLE;
        endcase
        d.sb   = strobe_for(d.st);
        d.rdy  = (d.st == ST_IDLE);
        t_load = (d.st != q.st);
        t_len  = len_of(d.st);
        ta_arm = (q.st == ST_RHLD) && (d.st == ST_IDLE);
        grab   = (q.st == ST_RACC) && t_done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.sb   <= strobe_for(ST_IDLE);
            q.addr <= '0;
            q.wdat <= '0;
            q.rdy  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    phase_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_len),
        .done     (t_done)
    );

    turn_guard #(.TA(T_TA), .W(TA_W)) guard_i (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (ta_arm),
        .clear (ta_clear)
    );

    read_capture #(.DATA_W(DATA_W)) cap_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .grab   (grab),
        .dq_in  (mem_dq_in),
        .rvalid (rsp_valid),
        .rdata  (rsp_rdata)
    );

    assign req_ready  = q.rdy;
    assign mem_addr   = q.addr;
    assign mem_dq_out = q.wdat;
    assign mem_cs1_n  = q.sb.cs1_n;
    assign mem_cs2    = q.sb.cs2;
    assign mem_oe_n   = q.sb.oe_n;
    assign mem_we_n   = q.sb.we_n;
    assign mem_dq_oe  = q.sb.drv;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs1_n && !mem_cs2 && mem_oe_n && mem_we_n && !mem_dq_oe)); // R1

    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R2

    AST_BUSY_HOLDS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> ($stable(mem_addr) && $stable(mem_dq_out))); // R2

    AST_WRITE_FULLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs1_n && mem_cs2 && mem_oe_n)); // R3

    AST_DRIVE_ONLY_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n && mem_oe_n)); // R4

    AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_dq_oe)); // R5

    AST_RVALID_AFTER_OE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(!mem_oe_n) && mem_oe_n)); // R6

endmodule

// File: tb/asram_ctrl_tb_top.sv
`timescale 1ns/1ps
module asram_ctrl_tb_top;
    localparam int AW    = 17;
    localparam int DW    = 8;
    localparam int T_AS  = 1;
    localparam int T_WP  = 3;
    localparam int T_WR  = 2;
    localparam int T_RD  = 4;
    localparam int T_RDH = 1;
    localparam int T_TA  = 3;

    localparam logic [4:0] SB_IDLE = 5'b10110;
    localparam logic [4:0] SB_SEL  = 5'b01110;
    localparam logic [4:0] SB_WPUL = 5'b01101;
    localparam logic [4:0] SB_RACC = 5'b01010;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    asram_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .T_AS(T_AS), .T_WP(T_WP), .T_WR(T_WR),
        .T_RD(T_RD), .T_RDH(T_RDH), .T_TA(T_TA)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // Memory model: stores on a fully selected strobe with the driver on,
    // returns junk until output enable has been low for two edges.
    logic [7:0] mem [int];
    int         oe_run = 0;
    wire        rd_act = !mem_cs1_n && mem_cs2 && !mem_oe_n;

    always @(posedge clk) begin
        if (!mem_cs1_n && mem_cs2 && !mem_we_n && mem_dq_oe)
            mem[int'(mem_addr)] = mem_dq_out;
        oe_run = rd_act ? oe_run + 1 : 0;
    end

    always_comb begin
        mem_dq_in = 8'h5A;
        if (rd_act && oe_run >= 2 && mem.exists(int'(mem_addr)))
            mem_dq_in = mem[int'(mem_addr)];
    end

    function automatic logic [4:0] sb_now();
        return {mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_dq_oe};
    endfunction

    function automatic logic [DW-1:0] pat(logic [AW-1:0] a, int salt);
        return DW'((a[7:0] ^ a[16:9]) + 8'h3C + DW'(salt * 29));
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle_check(string req);
        chk(sb_now() == SB_IDLE, req, "idle strobes", sb_now(), SB_IDLE);
        chk(req_ready == 1'b1, req, "ready in idle", req_ready, 1);
    endtask

    // Called at a negedge; returns at a negedge in the first idle cycle.
    task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] dat, int pre_idle, output int turn);
        repeat (pre_idle) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = dat;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a; req_wdata = ~dat;
        chk(req_ready == 1'b0, "R2", "ready after accept", req_ready, 0);
        turn = 0;
        while (mem_cs1_n && turn < 40) begin
            chk(sb_now() == SB_IDLE, "R7", "turnaround strobes", sb_now(), SB_IDLE);
            turn++;
            @(negedge clk);
        end
        for (int i = 0; i < T_AS; i++) begin
            chk(sb_now() == SB_SEL, "R3", "write setup", sb_now(), SB_SEL);
            chk(mem_addr == a, "R2", "addr held", mem_addr, a);
            @(negedge clk);
        end
        for (int i = 0; i < T_WP; i++) begin
            chk(sb_now() == SB_WPUL, "R3", "write pulse", sb_now(), SB_WPUL);
            chk(mem_dq_out == dat, "R4", "write byte", mem_dq_out, dat);
            chk(mem_addr == a, "R8", "write addr", mem_addr, a);
            @(negedge clk);
        end
        for (int i = 0; i < T_WR; i++) begin
            chk(sb_now() == SB_SEL, "R3", "write recovery", sb_now(), SB_SEL);
            chk(req_ready == 1'b0, "R2", "busy in recovery", req_ready, 0);
            @(negedge clk);
        end
        idle_check("R3");
    endtask

    task automatic do_read(logic [AW-1:0] a, logic [DW-1:0] exp);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = 8'hEE;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a;
        for (int i = 0; i < T_RD; i++) begin
            chk(sb_now() == SB_RACC, "R5", "read access", sb_now(), SB_RACC);
            chk(mem_addr == a, "R8", "read addr", mem_addr, a);
            chk(rsp_valid == 1'b0, "R6", "no early valid", rsp_valid, 0);
            @(negedge clk);
        end
        for (int i = 0; i < T_RDH; i++) begin
            chk(sb_now() == SB_SEL, "R5", "read hold", sb_now(), SB_SEL);
            chk(rsp_valid == (i == 0), "R6", "valid pulse", rsp_valid, (i == 0));
            if (i == 0) chk(rsp_rdata == exp, "R6", "read byte", rsp_rdata, exp);
            @(negedge clk);
        end
        chk(rsp_valid == 1'b0, "R6", "valid ends", rsp_valid, 0);
        idle_check("R5");
    endtask

    logic [AW-1:0] addrs [19];

    initial begin
        int turn;
        addrs[0] = '0;
        addrs[1] = '1;
        for (int k = 0; k < AW; k++) addrs[k + 2] = AW'(1) << k;

        repeat (3) @(negedge clk);
        chk(sb_now() == SB_IDLE, "R1", "reset strobes", sb_now(), SB_IDLE);
        chk(rsp_valid == 1'b0, "R1", "reset rsp_valid", rsp_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        idle_check("R1");

        // Back-to-back write sweep: no turnaround between writes (R7)
        for (int i = 0; i < 19; i++) begin
            do_write(addrs[i], pat(addrs[i], 0), 0, turn);
            chk(turn == 0, "R7", "write after write waits", turn, 0);
        end
        // Read back sweep (R8)
        for (int i = 0; i < 19; i++) do_read(addrs[i], pat(addrs[i], 0));

        // Read followed at once by writes: turnaround must appear (R7)
        for (int i = 0; i < 19; i += 3) begin
            do_read(addrs[i], pat(addrs[i], 0));
            do_write(addrs[i], pat(addrs[i], 1), 0, turn);
            chk(1 + turn >= T_TA, "R7", "deselect gap after read", 1 + turn, T_TA);
            do_read(addrs[i], pat(addrs[i], 1));
        end

        // Read, long idle gap, then write: no added wait (R7)
        for (int g = T_TA; g < T_TA + 3; g++) begin
            do_read(addrs[5], pat(addrs[5], 0));
            do_write(addrs[6], pat(addrs[6], g), g, turn);
            chk(turn == 0, "R7", "no wait after long gap", turn, 0);
            do_read(addrs[6], pat(addrs[6], g));
        end

        // Host changes request fields while busy: no effect (R2)
        do_write(17'h0ABCD, 8'h81, 0, turn);
        do_read(17'h0ABCD, 8'h81);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule